// File: doc/BRIEF.md
# Scan Storage Chain with Held Functional State

This block is a bank of N storage elements that all run on one system clock. Each element has three parts: a master register, a work slave and a shift slave. The work slave drives the element's bit of the parallel functional output. The shift slave takes its value straight from the master and feeds the next element in a single serial test chain.

A mode input selects between two behaviours. In work mode every master samples its own functional data bit, and both slaves follow it. In shift mode every master instead samples the shift slave of the element before it, and the first element samples a dedicated scan-in pin. Only the shift slaves move in this mode, so the work slaves keep the functional state from the last work cycle while arbitrary patterns pass through the chain.

A tester can therefore preload the chain, run one work cycle to capture the logic under test, and then shift the captured values out at the scan-out pin. The two clock phases of a master-slave pair are modelled here as one rising-edge update, which moves the chain one position per clock.

Top module: `scan_store_chain`

## Requirements
- R1: An active-high synchronous reset clears every master, work slave and shift slave. After reset the functional output `q` is all zeros and `scan_out` is 0, and shifting out the chain then yields N zeros.
- R2: With `shift_en` low, `q` equals the `d` value present at the previous rising edge.
- R3: With `shift_en` low, the chain also loads `d`. On the edge that captures `d`, `scan_out` shows `d[N-1]`. Each further shift-mode edge then presents `d[N-2]`, and so on down to `d[0]`.
- R4: With `shift_en` high, each rising edge moves the chain one position. Element 0 loads `scan_in` and element k loads element k-1. `scan_out` is element N-1, so a bit applied at `scan_in` appears at `scan_out` after N edges, and bits leave in the order they entered.
- R5: While `shift_en` is high, `q` does not change.
- R6: In shift mode, changes on `d` have no effect on either `q` or the data shifted out.
- R7: On the first edge after `shift_en` returns low, capture resumes: `q` takes the current `d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Mode select: 0 = work (capture `d`), 1 = shift (serial chain) |
| scan_in | input | 1 | Serial input to element 0 of the chain |
| d | input | N | Functional data inputs, one per element |
| q | output | N | Functional outputs from the work slaves |
| scan_out | output | 1 | Serial output from the shift slave of element N-1 |

## Verification
A work-mode capture shows up on `q` and at the head of `scan_out` one edge after the stimulus. A bit applied at `scan_in` in shift mode arrives at `scan_out` after exactly N edges, and later bits follow on each further edge.

The bench drives every stimulus one full cycle at a time and samples on the falling edge that follows the rising edge which consumed it. Expected serial bits go into a queue in the order they are due. The monitor pops one item only on those cycles whose post-edge `scan_out` is marked as due, so each comparison lines up with the cycle count above.

// File: rtl/scan_store_chain.sv
module scan_store_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         scan_in,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic         scan_out
);

  logic [N-1:0] mst;
  logic [N-1:0] wrk;
  logic [N-1:0] shs;
  logic [N-1:0] link_in;
  logic [N-1:0] mst_nxt;

  generate
    if (N == 1) begin : g_single
      assign link_in = scan_in;
    end else begin : g_multi
      assign link_in = {shs[N-2:0], scan_in};
    end
  endgenerate

  assign mst_nxt = shift_en ? link_in : d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst <= '0;
      wrk <= '0;
    end else begin
      mst <= mst_nxt;
      if (!shift_en) wrk <= mst_nxt;
    end
  end

  assign shs      = mst;
  assign q        = wrk;
  assign scan_out = shs[N-1];

endmodule

// File: rtl/scan_store_chain_chk.sv
module scan_store_chain_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_en,
  input logic         scan_in,
  input logic [N-1:0] d,
  input logic [N-1:0] q,
  input logic         scan_out,
  input logic [N-1:0] chain
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (q == '0) && (chain == '0) && !scan_out);

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> q == $past(d));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> chain == $past(d));

  p_head_r4: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> chain[0] == $past(scan_in));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> $stable(q));

  generate
    if (N > 1) begin : g_step
      p_step_r4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> chain[N-1:1] == $past(chain[N-2:0]));
      p_tail_r4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> scan_out == $past(chain[N-2]));
    end else begin : g_one
      p_tail_r4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> scan_out == $past(scan_in));
    end
  endgenerate

endmodule

bind scan_store_chain scan_store_chain_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .shift_en (shift_en),
  .scan_in  (scan_in),
  .d        (d),
  .q        (q),
  .scan_out (scan_out),
  .chain    (mst)
);

// File: tb/scan_store_chain_bench.sv
module scan_store_chain_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_en = 1'b0;
  logic         scan_in = 1'b0;
  logic [N-1:0] d = '0;
  logic [N-1:0] q;
  logic         scan_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic   exp_q[$];
  string  tag_q[$];
  bit     mon_take = 0;
  event   mon_ev;

  always #2.5 clk = ~clk;

  scan_store_chain #(.N(N)) u_scan_store_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .scan_in(scan_in),
    .d(d), .q(q), .scan_out(scan_out)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic b);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  always @(mon_ev) begin
    if (mon_take) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %b expected none (queue empty)", scan_out);
      end else begin
        chk(tag_q.pop_front(), {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, exp_q.pop_front()});
      end
    end
  end

  task automatic cyc(input logic sh, input logic si, input logic [N-1:0] dv, input bit take);
    shift_en = sh; scan_in = si; d = dv;
    @(posedge clk);
    @(negedge clk);
    mon_take = take;
    -> mon_ev;
    #0.1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] pat_a, pat_b, pat_p;
    pat_a = 8'hA5; pat_b = 8'h3C; pat_p = 8'b1011_0010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset q", q, '0);
    chk("R1 reset scan_out", {{(N-1){1'b0}}, scan_out}, '0);

    // R1/R4: empty chain drains zeros, then a 1 arrives after N edges
    for (int i = 0; i < N - 1; i++) push("R1 cleared chain", 1'b0);
    push("R4 latency N", 1'b1);
    cyc(1'b1, 1'b1, '0, 1'b1);
    for (int i = 1; i < N; i++) cyc(1'b1, 1'b0, '0, 1'b1);
    chk("R5 q held during shift", q, '0);

    // R2/R3: capture A, then shift it out while d toggles (R6)
    push("R3 capture head", pat_a[N-1]);
    cyc(1'b0, 1'b0, pat_a, 1'b1);
    chk("R2 capture q", q, pat_a);
    for (int i = N - 2; i >= 0; i--) begin
      push("R3 captured bit", pat_a[i]);
      cyc(1'b1, 1'b0, ~pat_a ^ N'(i), 1'b1);
      chk("R5 R6 q held while d changes", q, pat_a);
    end

    // R4: shift a pattern fully in then out; order preserved
    for (int i = 0; i < N; i++) push("R4 pattern order", pat_p[i]);
    for (int i = 0; i < N; i++) cyc(1'b1, pat_p[i], N'(i * 37), i == N - 1);
    chk("R5 q held after pattern", q, pat_a);
    for (int i = 1; i < N; i++) cyc(1'b1, 1'b0, 8'hFF, 1'b1);
    chk("R6 q unaffected by d", q, pat_a);

    // R7: back to work mode, capture resumes, captured values shift out
    push("R7 capture head", pat_b[N-1]);
    cyc(1'b0, 1'b1, pat_b, 1'b1);
    chk("R7 resume capture q", q, pat_b);
    for (int i = N - 2; i >= 0; i--) begin
      push("R3 R6 capture shift", pat_b[i]);
      cyc(1'b1, 1'b1, 8'h00, 1'b1);
    end
    chk("R5 q held after drain", q, pat_b);

    // R2: consecutive work cycles
    cyc(1'b0, 1'b0, 8'h5A, 1'b0);
    chk("R2 second capture", q, 8'h5A);
    cyc(1'b0, 1'b0, 8'h81, 1'b0);
    chk("R2 third capture", q, 8'h81);

    // R1: reset mid-shift clears everything
    cyc(1'b1, 1'b1, '0, 1'b0);
    rst = 1'b1;
    cyc(1'b1, 1'b1, '0, 1'b0);
    rst = 1'b0;
    chk("R1 mid reset q", q, '0);
    chk("R1 mid reset scan_out", {{(N-1){1'b0}}, scan_out}, '0);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule